// File: doc/BRIEF.md
# Nested Prioritized Interrupt Sequencer

This block turns 32 interrupt request lines into handler entries for a processor and runs the entry and exit steps in hardware. Each line has a 2-bit priority that can be rewritten at any time through a small write port. The sequencer records a request as pending on its rising edge. It picks the most urgent eligible line and decides whether that line may interrupt the code that is running. On entry it saves eight context words on a memory stack and reads the handler address from a vector table. It then signals the handler start with a single-cycle pulse.

When a handler ends, the processor pulses the exit input. If another eligible request is waiting, the sequencer fetches that handler's vector directly and keeps the saved frame (tail chaining). If none is waiting, it reads the eight words back and hands them to the processor. A more urgent request that arrives during stacking or during the vector read takes over the entry in progress. The words already stacked are kept (late arrival). All stack and table accesses use one memory port with a valid/ready handshake.

Top module: `nest_irq_seq`

## Requirements
- R1: Each line has a 2-bit priority written through `cfg_we_i`/`cfg_idx_i`/`cfg_prio_i`. A write changes only the addressed line and takes effect for every later arbitration.
- R2: A line becomes pending on a 0-to-1 transition of its request. A request held high after its handler has run does not start it again.
- R3: Among the pending lines that are not active, the smallest priority value is the most urgent. On a tie, the lowest line number wins.
- R4: A request starts an entry only when its priority value is strictly below the current execution priority. That is the priority of the most recently entered active handler, or 4 (idle) when none is active. A request that is not strictly more urgent stays pending.
- R5: An entry writes eight words to addresses SP-32+4k for k = 0..7, where SP is the stack pointer before the entry. Word k is `ctx_i[32k+31:32k]` (order: R0, R1, R2, R3, R12, LR, PC, status). SP then drops by 32. The reset value of SP is `SP_RESET` (0x2000_1000).
- R6: The vector is read at `vtab_base_i` + 4*(16 + line). One cycle after that read completes, `hdl_start_o` is high for exactly one cycle, with `hdl_addr_o` equal to the word read and `hdl_irq_o` equal to the line.
- R7: On exit with no eligible request, the block reads eight words at SP+4k, raises SP by 32 and pulses `ctx_load_o` for one cycle. At that pulse, `ctx_o` holds the words read, in the layout of R5.
- R8: On exit, a pending request that is strictly more urgent than the priority exposed by the exit is entered directly. Only its vector read takes place, with no stack write or read.
- R9: A strictly more urgent request that arrives during stacking becomes the handler entered. The stacking is not repeated, so the entry has exactly eight writes.
- R10: A strictly more urgent request that arrives during the vector read causes a second vector read, for the new line, once the first completes. The new line is the one started.
- R11: A rising request on a line whose handler is active sets it pending again. It is entered after that handler exits.
- R12: While `mem_req_o` is high and `mem_ready_i` is low, request, address and direction stay unchanged.
- R13: After reset, there is no memory request, no start pulse and no context load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Interrupt request lines |
| cfg_we_i | input | 1 | Priority write strobe |
| cfg_idx_i | input | 5 | Line whose priority is written |
| cfg_prio_i | input | 2 | Priority value written |
| vtab_base_i | input | 32 | Vector table base address |
| ctx_i | input | 256 | Live processor context, word k in bits 32k+31:32k |
| ctx_o | output | 256 | Restored context, same layout |
| ctx_load_o | output | 1 | One-cycle pulse: restored context valid |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = stack write, 0 = read |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Memory accepts or completes the access |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| hdl_start_o | output | 1 | One-cycle handler start pulse |
| hdl_addr_o | output | 32 | Handler start address |
| hdl_irq_o | output | 5 | Line being entered |
| hdl_exit_i | input | 1 | One-cycle handler exit pulse |

## Verification
The bench builds the block with its default parameters: 32 lines, 2-bit priorities, a four-deep active stack and 32-bit words. At these values all four priority levels can nest, and tail chaining can be checked across a full set of pending lines. The memory model gives random ready delays and can hold the vector read back. That holding makes the narrow late-arrival windows in stacking and in the vector read reachable on demand. Random rounds load random priorities, raise a random set of lines at once and check the whole chain of entries against a computed order.

// File: rtl/nest_irq_seq.sv
package nest_irq_seq_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_PUSH, ST_VEC, ST_POP} seq_st_e;
endpackage

module nest_irq_pend #(
  parameter int unsigned N  = 32,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_i,
  input  logic          acc_vld_i,
  input  logic [IW-1:0] acc_id_i,
  input  logic          ret_vld_i,
  input  logic [IW-1:0] ret_id_i,
  output logic [N-1:0]  pend_o,
  output logic [N-1:0]  act_o
);
  logic [N-1:0] irq_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_i;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic p_q, a_q;
    logic acc_me, ret_me;
    assign acc_me = acc_vld_i && (acc_id_i == IW'(i));
    assign ret_me = ret_vld_i && (ret_id_i == IW'(i));
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        p_q <= 1'b0;
        a_q <= 1'b0;
      end else begin
        // a new edge wins over acceptance so a recurrence is never lost
        if (irq_i[i] && !irq_q[i]) p_q <= 1'b1;
        else if (acc_me)           p_q <= 1'b0;
        if (acc_me)      a_q <= 1'b1;
        else if (ret_me) a_q <= 1'b0;
      end
    assign pend_o[i] = p_q;
    assign act_o[i]  = a_q;
  end
endmodule

module nest_irq_arb #(
  parameter int unsigned N  = 32,
  parameter int unsigned PW = 2,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]         req_i,
  input  logic [N-1:0][PW-1:0] prio_i,
  output logic                 vld_o,
  output logic [IW-1:0]        id_o,
  output logic [PW-1:0]        prio_o
);
  logic          b_v;
  logic [IW-1:0] b_id;
  logic [PW-1:0] b_p;

  // scan downward with <= so the lowest index survives a tie
  always_comb begin
    b_v  = 1'b0;
    b_id = '0;
    b_p  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i] && (!b_v || prio_i[i] <= b_p)) begin
        b_v  = 1'b1;
        b_id = IW'(i);
        b_p  = prio_i[i];
      end
    end
  end

  assign vld_o  = b_v;
  assign id_o   = b_id;
  assign prio_o = b_p;
endmodule

module nest_irq_stack #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PW    = 2,
  parameter int unsigned IW    = 5,
  localparam int unsigned DPW  = $clog2(DEPTH + 1),
  localparam int unsigned AIW  = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [PW-1:0] push_prio_i,
  input  logic [IW-1:0] push_id_i,
  input  logic          pop_i,
  output logic [PW:0]   cur_prio_o,
  output logic [PW:0]   below_prio_o,
  output logic [IW-1:0] top_id_o,
  output logic          empty_o
);
  localparam logic [PW:0] IDLE = {1'b1, {PW{1'b0}}};

  logic [PW-1:0] prio_q [DEPTH];
  logic [IW-1:0] id_q   [DEPTH];
  logic [DPW-1:0] dep_q;
  logic [AIW-1:0] top_idx, bel_idx, wr_idx;

  assign wr_idx  = AIW'(dep_q);
  assign top_idx = AIW'(dep_q - DPW'(1));
  assign bel_idx = AIW'(dep_q - DPW'(2));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      dep_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        prio_q[i] <= '0;
        id_q[i]   <= '0;
      end
    end else if (push_i) begin
      prio_q[wr_idx] <= push_prio_i;
      id_q[wr_idx]   <= push_id_i;
      dep_q          <= dep_q + DPW'(1);
    end else if (pop_i) begin
      dep_q <= dep_q - DPW'(1);
    end

  assign empty_o      = (dep_q == '0);
  assign cur_prio_o   = empty_o ? IDLE : {1'b0, prio_q[top_idx]};
  assign below_prio_o = (dep_q < DPW'(2)) ? IDLE : {1'b0, prio_q[bel_idx]};
  assign top_id_o     = id_q[top_idx];
endmodule

module nest_irq_seq
  import nest_irq_seq_pkg::*;
#(
  parameter int unsigned N_IRQ     = 32,
  parameter int unsigned PW        = 2,
  parameter int unsigned W         = 32,
  parameter int unsigned CTX_WORDS = 8,
  parameter int unsigned VEC_OFS   = 16,
  parameter logic [W-1:0] SP_RESET = 32'h2000_1000,
  localparam int unsigned IW = $clog2(N_IRQ),
  localparam int unsigned CW = $clog2(CTX_WORDS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_IRQ-1:0]       irq_i,
  input  logic                   cfg_we_i,
  input  logic [IW-1:0]          cfg_idx_i,
  input  logic [PW-1:0]          cfg_prio_i,
  input  logic [W-1:0]           vtab_base_i,
  input  logic [CTX_WORDS*W-1:0] ctx_i,
  output logic [CTX_WORDS*W-1:0] ctx_o,
  output logic                   ctx_load_o,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [W-1:0]           mem_addr_o,
  output logic [W-1:0]           mem_wdata_o,
  input  logic                   mem_ready_i,
  input  logic [W-1:0]           mem_rdata_i,
  output logic                   hdl_start_o,
  output logic [W-1:0]           hdl_addr_o,
  output logic [IW-1:0]          hdl_irq_o,
  input  logic                   hdl_exit_i
);
  localparam logic [W-1:0]  FRAME_B  = W'(CTX_WORDS * 4);
  localparam logic [CW-1:0] CNT_LAST = CW'(CTX_WORDS - 1);

  seq_st_e st_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sp_q;
  logic [IW-1:0] sel_q;
  logic [PW-1:0] sel_prio_q;
  logic [CTX_WORDS-1:0][W-1:0] ctx_q, ctx_w;
  logic [N_IRQ-1:0][PW-1:0] prio_q;
  logic start_q, load_q;
  logic [W-1:0]  haddr_q;
  logic [IW-1:0] hirq_q;

  logic [N_IRQ-1:0] pend, act, ret_oh, cand;
  logic win_vld;
  logic [IW-1:0] win_id, top_id;
  logic [PW-1:0] win_prio;
  logic [PW:0] cur_prio, below_prio;
  logic stk_empty, exit_go, chain, preempt, redirect, vec_done, accept;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       prio_q <= '0;
    else if (cfg_we_i) prio_q[cfg_idx_i] <= cfg_prio_i;

  assign exit_go  = (st_q == ST_RUN) && hdl_exit_i && !stk_empty;
  // the exiting line no longer counts as active, so its recurrence can chain
  assign ret_oh   = exit_go ? (N_IRQ'(1) << top_id) : '0;
  assign cand     = pend & ~(act & ~ret_oh);
  assign chain    = exit_go && win_vld && ({1'b0, win_prio} < below_prio);
  assign preempt  = (st_q == ST_RUN) && !exit_go && win_vld && ({1'b0, win_prio} < cur_prio);
  assign redirect = win_vld && (win_prio < sel_prio_q);
  assign vec_done = (st_q == ST_VEC) && mem_ready_i;
  assign accept   = vec_done && !redirect;

  nest_irq_pend #(.N(N_IRQ)) u_pend (
    .clk_i, .rst_ni, .irq_i,
    .acc_vld_i(accept), .acc_id_i(sel_q),
    .ret_vld_i(exit_go), .ret_id_i(top_id),
    .pend_o(pend), .act_o(act)
  );

  nest_irq_arb #(.N(N_IRQ), .PW(PW)) u_arb (
    .req_i(cand), .prio_i(prio_q),
    .vld_o(win_vld), .id_o(win_id), .prio_o(win_prio)
  );

  nest_irq_stack #(.DEPTH(2 ** PW), .PW(PW), .IW(IW)) u_stk (
    .clk_i, .rst_ni,
    .push_i(accept), .push_prio_i(sel_prio_q), .push_id_i(sel_q),
    .pop_i(exit_go),
    .cur_prio_o(cur_prio), .below_prio_o(below_prio),
    .top_id_o(top_id), .empty_o(stk_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q       <= ST_RUN;
      cnt_q      <= '0;
      sp_q       <= SP_RESET;
      sel_q      <= '0;
      sel_prio_q <= '0;
      ctx_q      <= '0;
      start_q    <= 1'b0;
      load_q     <= 1'b0;
      haddr_q    <= '0;
      hirq_q     <= '0;
    end else begin
      start_q <= 1'b0;
      load_q  <= 1'b0;
      unique case (st_q)
        ST_RUN: begin
          if (chain || preempt) begin
            sel_q      <= win_id;
            sel_prio_q <= win_prio;
            cnt_q      <= '0;
            st_q       <= chain ? ST_VEC : ST_PUSH;
          end else if (exit_go) begin
            cnt_q <= '0;
            st_q  <= ST_POP;
          end
        end
        ST_PUSH: begin
          if (redirect) begin
            sel_q      <= win_id;
            sel_prio_q <= win_prio;
          end
          if (mem_ready_i) begin
            cnt_q <= cnt_q + CW'(1);
            if (cnt_q == CNT_LAST) begin
              sp_q <= sp_q - FRAME_B;
              st_q <= ST_VEC;
            end
          end
        end
        ST_VEC: begin
          if (mem_ready_i) begin
            if (redirect) begin
              sel_q      <= win_id;
              sel_prio_q <= win_prio;
            end else begin
              start_q <= 1'b1;
              haddr_q <= mem_rdata_i;
              hirq_q  <= sel_q;
              st_q    <= ST_RUN;
            end
          end
        end
        ST_POP: begin
          if (mem_ready_i) begin
            ctx_q[cnt_q] <= mem_rdata_i;
            cnt_q        <= cnt_q + CW'(1);
            if (cnt_q == CNT_LAST) begin
              sp_q   <= sp_q + FRAME_B;
              load_q <= 1'b1;
              st_q   <= ST_RUN;
            end
          end
        end
        default: st_q <= ST_RUN;
      endcase
    end

  assign ctx_w = ctx_i;

  always_comb begin
    unique case (st_q)
      ST_PUSH: mem_addr_o = sp_q - FRAME_B + (W'(cnt_q) << 2);
      ST_VEC:  mem_addr_o = vtab_base_i + ((W'(sel_q) + W'(VEC_OFS)) << 2);
      ST_POP:  mem_addr_o = sp_q + (W'(cnt_q) << 2);
      default: mem_addr_o = '0;
    endcase
  end

  assign mem_req_o   = (st_q != ST_RUN);
  assign mem_we_o    = (st_q == ST_PUSH);
  assign mem_wdata_o = ctx_w[cnt_q];
  assign ctx_o       = ctx_q;
  assign ctx_load_o  = load_q;
  assign hdl_start_o = start_q;
  assign hdl_addr_o  = haddr_q;
  assign hdl_irq_o   = hirq_q;
endmodule

// File: rtl/nest_irq_seq_chk.sv
module nest_irq_seq_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         mem_req_o,
  input logic         mem_we_o,
  input logic         mem_ready_i,
  input logic [W-1:0] mem_addr_o,
  input logic [W-1:0] mem_rdata_i,
  input logic         hdl_start_o,
  input logic [W-1:0] hdl_addr_o,
  input logic         ctx_load_o
);
  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  p_start_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdl_start_o |=> !hdl_start_o);

  p_start_after_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdl_start_o |-> $past(mem_req_o && mem_ready_i && !mem_we_o));

  p_start_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdl_start_o |-> hdl_addr_o == $past(mem_rdata_i));

  p_start_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdl_start_o |-> !mem_req_o);

  p_load_after_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_load_o |-> $past(mem_req_o && mem_ready_i && !mem_we_o));

  p_load_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_load_o |-> !mem_req_o && !hdl_start_o);
endmodule

bind nest_irq_seq nest_irq_seq_chk #(.W(W)) u_chk (.*);

// File: tb/sim_nest_irq_seq.sv
`timescale 1ns/100ps
module sim_nest_irq_seq;
  localparam logic [31:0] SP0 = 32'h2000_1000;
  localparam logic [31:0] VT  = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_idx = '0;
  logic [1:0] cfg_prio = '0;
  logic [255:0] ctx = '0;
  logic [255:0] ctx_o;
  logic ctx_load, mem_req, mem_we, mem_ready, hdl_start, hdl_exit;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, hdl_addr;
  logic [4:0] hdl_irq;

  always #2 clk = ~clk;

  nest_irq_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_prio_i(cfg_prio),
    .vtab_base_i(VT), .ctx_i(ctx), .ctx_o(ctx_o), .ctx_load_o(ctx_load),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .hdl_start_o(hdl_start), .hdl_addr_o(hdl_addr), .hdl_irq_o(hdl_irq),
    .hdl_exit_i(hdl_exit)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;
  bit hold_vec = 1'b0;
  logic [1:0] pr [32];

  logic [31:0] smem [logic [31:0]];
  int wr_n, rd_n, vec_n, hold_err;
  logic [31:0] wr_addr [32];
  logic [31:0] wr_data [32];
  logic [31:0] rd_addr [32];
  logic [31:0] vec_addr [8];
  bit prev_wait;
  logic [31:0] prev_addr;

  function automatic bit is_vec(logic [31:0] a);
    return a >= VT && a < VT + 32'd192;
  endfunction
  function automatic logic [31:0] vec_val(int id);
    return 32'h0800_0000 + 32'(id) * 32'd64;
  endfunction
  function automatic logic [31:0] exp_vaddr(int id);
    return VT + 32'd4 * (32'd16 + 32'(id));
  endfunction
  function automatic int exp_winner(logic [31:0] m);
    int b = -1;
    for (int i = 0; i < 32; i++)
      if (m[i] && (b < 0 || pr[i] < pr[b])) b = i;
    return b;
  endfunction

  // memory model: random ready, logs every completed access
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
      prev_wait = 1'b0;
    end else begin
      if (prev_wait && !(mem_req && mem_addr == prev_addr)) hold_err++;
      mem_ready = (hold_vec && mem_req && !mem_we && is_vec(mem_addr)) ? 1'b0
                : (($urandom % 4) != 0);
      if (is_vec(mem_addr)) mem_rdata = vec_val((mem_addr - VT) / 4 - 16);
      else if (smem.exists(mem_addr)) mem_rdata = smem[mem_addr];
      else mem_rdata = 32'hDEAD_BEEF;
      if (mem_req && mem_ready) begin
        if (mem_we) begin
          smem[mem_addr] = mem_wdata;
          if (wr_n < 32) begin wr_addr[wr_n] = mem_addr; wr_data[wr_n] = mem_wdata; end
          wr_n++;
        end else if (is_vec(mem_addr)) begin
          if (vec_n < 8) vec_addr[vec_n] = mem_addr;
          vec_n++;
        end else begin
          if (rd_n < 32) rd_addr[rd_n] = mem_addr;
          rd_n++;
        end
      end
      prev_wait = mem_req && !mem_ready;
      prev_addr = mem_addr;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic cyc(input int n);
    repeat (n) tick();
  endtask

  task automatic clr_log();
    wr_n = 0; rd_n = 0; vec_n = 0;
  endtask

  task automatic set_prio(input int id, input logic [1:0] p);
    cfg_we = 1'b1; cfg_idx = 5'(id); cfg_prio = p; pr[id] = p;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic set_ctx(input logic [31:0] base);
    for (int k = 0; k < 8; k++) ctx[k*32 +: 32] = base + 32'(k);
  endtask

  task automatic pulse_exit();
    hdl_exit = 1'b1;
    tick();
    hdl_exit = 1'b0;
  endtask

  task automatic wait_start(input string rq, input int exp_id);
    int t = 0;
    tick();
    while (!hdl_start && t < 4000) begin tick(); t++; end
    chk(hdl_start, rq, 32'(hdl_start), 32'd1);
    chk(hdl_irq == 5'(exp_id), rq, 32'(hdl_irq), 32'(exp_id));
    chk(hdl_addr == vec_val(exp_id), rq, hdl_addr, vec_val(exp_id));
  endtask

  task automatic wait_load(input string rq);
    int t = 0;
    tick();
    while (!ctx_load && t < 4000) begin tick(); t++; end
    chk(ctx_load, rq, 32'(ctx_load), 32'd1);
  endtask

  task automatic quiet(input string rq, input int n);
    int seen = 0;
    repeat (n) begin tick(); if (hdl_start) seen++; end
    chk(seen == 0, rq, 32'(seen), 32'd0);
  endtask

  task automatic chk_ctx(input string rq, input logic [255:0] exp);
    for (int k = 0; k < 8; k++)
      chk(ctx_o[k*32 +: 32] == exp[k*32 +: 32], rq, ctx_o[k*32 +: 32], exp[k*32 +: 32]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [255:0] ctx_a, ctx_b;
    hdl_exit = 1'b0;
    mem_rdata = '0;
    process::self().srandom(32'd1234);
    for (int i = 0; i < 32; i++) pr[i] = 2'd0;
    clr_log();
    hold_err = 0;
    cyc(4);
    rst_n = 1'b1;
    tick();
    // R13 reset state
    chk(!mem_req, "R13", 32'(mem_req), 32'd0);
    chk(!hdl_start, "R13", 32'(hdl_start), 32'd0);
    chk(!ctx_load, "R13", 32'(ctx_load), 32'd0);

    // R5 R6 R7 R2: single entry and exit
    set_ctx(32'hC0DE_0000); ctx_a = ctx;
    set_prio(5, 2'd2);
    clr_log();
    irq[5] = 1'b1;
    wait_start("R6", 5);
    chk(wr_n == 8, "R5", 32'(wr_n), 32'd8);
    for (int k = 0; k < 8; k++) begin
      chk(wr_addr[k] == SP0 - 32 + 32'(4 * k), "R5", wr_addr[k], SP0 - 32 + 32'(4 * k));
      chk(wr_data[k] == ctx_a[k*32 +: 32], "R5", wr_data[k], ctx_a[k*32 +: 32]);
    end
    chk(vec_n == 1 && vec_addr[0] == exp_vaddr(5), "R6", vec_addr[0], exp_vaddr(5));
    tick();
    chk(!hdl_start, "R6", 32'(hdl_start), 32'd0);
    set_ctx(32'h1111_0000);
    clr_log();
    pulse_exit();
    wait_load("R7");
    chk_ctx("R7", ctx_a);
    chk(rd_n == 8, "R7", 32'(rd_n), 32'd8);
    for (int k = 0; k < 8; k++)
      chk(rd_addr[k] == SP0 - 32 + 32'(4 * k), "R7", rd_addr[k], SP0 - 32 + 32'(4 * k));
    quiet("R2", 20);
    irq = '0;
    tick();

    // R4 R7 R8: nesting, equal priority held back, chain after exit
    set_ctx(32'hAAAA_0000); ctx_a = ctx;
    set_prio(3, 2'd1);
    set_prio(7, 2'd1);
    set_prio(9, 2'd0);
    irq[3] = 1'b1;
    wait_start("R4", 3);
    irq[7] = 1'b1;
    quiet("R4", 20);
    set_ctx(32'hBBBB_0000); ctx_b = ctx;
    clr_log();
    irq[9] = 1'b1;
    wait_start("R4", 9);
    chk(wr_addr[0] == SP0 - 64, "R5", wr_addr[0], SP0 - 64);
    clr_log();
    pulse_exit();
    wait_load("R7");
    chk_ctx("R7", ctx_b);
    chk(rd_addr[0] == SP0 - 64, "R7", rd_addr[0], SP0 - 64);
    clr_log();
    pulse_exit();
    wait_start("R8", 7);
    chk(wr_n == 0 && rd_n == 0, "R8", 32'(wr_n + rd_n), 32'd0);
    chk(vec_n == 1 && vec_addr[0] == exp_vaddr(7), "R8", vec_addr[0], exp_vaddr(7));
    clr_log();
    pulse_exit();
    wait_load("R7");
    chk_ctx("R7", ctx_a);
    chk(rd_addr[0] == SP0 - 32, "R7", rd_addr[0], SP0 - 32);
    irq = '0;
    tick();

    // R9 late arrival during stacking
    set_prio(20, 2'd3);
    set_prio(21, 2'd0);
    clr_log();
    irq[20] = 1'b1;
    while (wr_n < 2) tick();
    irq[21] = 1'b1;
    wait_start("R9", 21);
    chk(wr_n == 8, "R9", 32'(wr_n), 32'd8);
    chk(wr_addr[0] == SP0 - 32, "R9", wr_addr[0], SP0 - 32);
    chk(vec_n == 1 && vec_addr[0] == exp_vaddr(21), "R9", vec_addr[0], exp_vaddr(21));
    pulse_exit();
    wait_start("R8", 20);
    pulse_exit();
    wait_load("R7");
    irq = '0;
    tick();

    // R10 late arrival during the vector read
    set_prio(10, 2'd2);
    set_prio(11, 2'd1);
    clr_log();
    hold_vec = 1'b1;
    irq[10] = 1'b1;
    while (!(mem_req && !mem_we)) tick();
    irq[11] = 1'b1;
    cyc(3);
    hold_vec = 1'b0;
    wait_start("R10", 11);
    chk(vec_n == 2, "R10", 32'(vec_n), 32'd2);
    chk(vec_addr[0] == exp_vaddr(10), "R10", vec_addr[0], exp_vaddr(10));
    chk(vec_addr[1] == exp_vaddr(11), "R10", vec_addr[1], exp_vaddr(11));
    chk(wr_n == 8, "R10", 32'(wr_n), 32'd8);
    pulse_exit();
    wait_start("R8", 10);
    pulse_exit();
    wait_load("R7");
    irq = '0;
    tick();

    // R11 recurrence while active
    set_prio(2, 2'd1);
    irq[2] = 1'b1;
    wait_start("R11", 2);
    irq[2] = 1'b0;
    tick();
    irq[2] = 1'b1;
    quiet("R11", 10);
    pulse_exit();
    wait_start("R11", 2);
    pulse_exit();
    wait_load("R11");
    irq = '0;
    tick();

    // R1 R3: random priorities, a burst of lines, full chain order
    for (int t = 0; t < 10; t++) begin
      logic [31:0] rem;
      for (int i = 0; i < 32; i++) set_prio(i, 2'($urandom % 4));
      rem = $urandom & $urandom & $urandom;
      if (rem == 0) rem = 32'h8000_0001;
      irq = rem;
      while (rem != 0) begin
        int w;
        w = exp_winner(rem);
        wait_start("R3", w);
        rem[w] = 1'b0;
        pulse_exit();
      end
      wait_load("R1");
      irq = '0;
      tick();
    end

    chk(hold_err == 0, "R12", 32'(hold_err), 32'd0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule